// File: doc/BRIEF.md
# Chip-Select External Bus Sequencer

This block carries out one external bus transaction at a time for an internal requester. A request gives an address, a transfer size (byte, word, longword or 16-byte line), a direction, the write data and a burst flag. The address is compared against a set of programmable chip-select windows. Each window carries its own port width, byte-strobe policy for reads, acknowledge source and wait-state count. A transfer wider than the selected port is cut into consecutive port-sized accesses. Each access drives a one-clock address-latch strobe, the window's chip select, output enable on reads, per-lane byte strobes and a two-bit size code.

All bus strobes are active-low and come straight from flip-flops. An access ends either after the window's programmed number of wait states or when the external acknowledge is seen low, depending on the window. Read bytes are collected most-significant-first into a result register. The requester sees `busy` while a transaction runs and a one-clock `done` pulse at its end. `done_err` flags a request whose address hit no window. Such a request never reaches the bus.

Top module: `cs_bus_seq`

## Requirements
- R1: Window i matches when `cfg_en[i]` is set and `(addr & cfg_mask[i]) == (cfg_base[i] & cfg_mask[i])`; the lowest matching index wins, and only that window's `bus_cs_n` bit goes low during its accesses.
- R2: A request that matches no window yields `done` and `done_err` high in the cycle after it is sampled; no address-latch, chip-select, output-enable or byte strobe asserts for it.
- R3: With n = min(transfer bytes, port bytes), where sizes are 1, 2, 4 and 16 bytes and port codes 00/01/10 mean 1/2/4 bytes (11 acts as 4), a transfer takes (transfer bytes / n) accesses; access j presents address `req_addr + j*n` on `bus_addr`.
- R4: Size codes on `req_size` and `bus_tsiz` are 00 longword, 01 byte, 10 word, 11 line. Without burst, the first access shows the code of the whole transfer and every later access shows the code of n.
- R5: With `req_burst` set, every access of the transfer shows the code of the whole transfer.
- R6: Byte lane k (k = 0 on `bus_dout[31:24]`, k = 3 on `[7:0]`) is driven by `bus_be_n[3-k]`. A port of p bytes uses lanes 0..p-1, and the byte at address a sits in lane a mod p. Only the n lanes starting at lane (address mod p) have their strobe low; written bytes appear on those lanes in address order.
- R7: When a window's `cfg_rd_strobe` is 0, all byte strobes stay high on its read accesses; when 1, reads strobe lanes as in R6.
- R8: `bus_oe_n` is low only during read accesses and only while a chip select is low.
- R9: With `cfg_auto_ack` set and wait count W, each access holds chip select low for W+2 clocks, and `bus_ta_n` has no effect.
- R10: With `cfg_auto_ack` clear, `bus_ta_n` is sampled on every rising edge after the address-latch clock; the access ends on the first such edge that sees it low.
- R11: On writes, `bus_dout_en` stays high and `bus_dout` unchanged in the clock after chip select negates; `bus_dout_en` is low by the time `done` pulses.
- R12: On reads, `done_rdata` holds the transfer's bytes in its low bits, lowest address most significant, valid while `done` is high.
- R13: `bus_ale_n` is low for exactly one clock at the start of every access and high otherwise; out of reset all bus strobes are high and `busy` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_addr | input | AW | Transfer start address, aligned to its size |
| req_size | input | 2 | Transfer size code |
| req_write | input | 1 | 1 for write, 0 for read |
| req_burst | input | 1 | Hold the whole-transfer size code on all accesses |
| req_wdata | input | 128 | Write data, right-aligned, big-endian |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |
| done_err | output | 1 | Completed request hit no window |
| done_rdata | output | 128 | Assembled read data |
| cfg_en | input | NCS | Window enables |
| cfg_base | input | NCS x AW | Window base addresses |
| cfg_mask | input | NCS x AW | Window compare masks |
| cfg_pw | input | NCS x 2 | Window port width code |
| cfg_rd_strobe | input | NCS | Strobe byte lanes on reads |
| cfg_auto_ack | input | NCS | End accesses on the internal wait counter |
| cfg_waits | input | NCS x WAIT_W | Wait-state count |
| bus_addr | output | AW | Access address |
| bus_ale_n | output | 1 | Address-latch strobe |
| bus_cs_n | output | NCS | Chip selects |
| bus_oe_n | output | 1 | Output enable |
| bus_be_n | output | 4 | Byte strobes |
| bus_tsiz | output | 2 | Size code |
| bus_dout | output | 32 | Write data |
| bus_dout_en | output | 1 | Write data driven |
| bus_din | input | 32 | Read data |
| bus_ta_n | input | 1 | External transfer acknowledge |

## Verification
The bench sweeps every pairing of port width, transfer size, direction and burst flag. It uses a start offset that lands on a non-zero lane, and it varies the wait count, the acknowledge source and the read-strobe policy. Every access is checked against address, size code, lanes, chip select and duration worked out arithmetically. A design that took the later-beat size code from the transfer instead of the port, or that still switched codes under burst, fails on the narrow ports. A design that placed narrow-port bytes on the low lanes fails on the lane and data checks. An access that listened to the acknowledge in auto mode would end early, since the acknowledge is held low. The overlapping fourth window catches inverted priority, and a disabled window catches a decode that ignores the enable. An unmatched address must finish in one clock with no strobe at all.

// File: rtl/csbus_pkg.sv
package csbus_pkg;

    localparam int BUS_BYTES  = 4;
    localparam int LINE_BYTES = 16;
    localparam int XFER_W     = LINE_BYTES * 8;

    typedef enum logic [1:0] {
        TSZ_LONG = 2'b00,
        TSZ_BYTE = 2'b01,
        TSZ_WORD = 2'b10,
        TSZ_LINE = 2'b11
    } tsize_e;

    typedef enum logic [1:0] {
        PW_8   = 2'b00,
        PW_16  = 2'b01,
        PW_32  = 2'b10,
        PW_32X = 2'b11
    } pwidth_e;

    typedef struct packed {
        tsize_e size;
        logic   wr;
        logic   burst;
    } req_ctx_t;

    typedef struct packed {
        pwidth_e pw;
        logic    rd_strobe;
        logic    auto_ack;
    } win_attr_t;

    function automatic logic [4:0] size_bytes(tsize_e s);
        case (s)
            TSZ_BYTE: return 5'd1;
            TSZ_WORD: return 5'd2;
            TSZ_LONG: return 5'd4;
            default:  return 5'd16;
        endcase
    endfunction

    function automatic logic [2:0] port_bytes(pwidth_e p);
        case (p)
            PW_8:    return 3'd1;
            PW_16:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Low address bits that select a lane inside the port.
    function automatic logic [1:0] port_mask(pwidth_e p);
        case (p)
            PW_8:    return 2'b00;
            PW_16:   return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [2:0] access_bytes(tsize_e s, pwidth_e p);
        logic [4:0] sb;
        logic [2:0] pb;
        sb = size_bytes(s);
        pb = port_bytes(p);
        if (sb < {2'b00, pb}) return sb[2:0];
        return pb;
    endfunction

    function automatic tsize_e code_of(logic [2:0] n);
        case (n)
            3'd1:    return TSZ_BYTE;
            3'd2:    return TSZ_WORD;
            default: return TSZ_LONG;
        endcase
    endfunction

    function automatic logic [4:0] beat_count(tsize_e s, pwidth_e p);
        logic [4:0] sb;
        sb = size_bytes(s);
        case (access_bytes(s, p))
            3'd1:    return sb;
            3'd2:    return sb >> 1;
            default: return sb >> 2;
        endcase
    endfunction

endpackage

// File: rtl/cs_window_match.sv
module cs_window_match
    import csbus_pkg::*;
#(
    parameter int NCS   = 4,
    parameter int AW    = 32,
    localparam int IDX_W = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic [AW-1:0]           addr,
    input  logic [NCS-1:0]          en,
    input  logic [NCS-1:0][AW-1:0]  base,
    input  logic [NCS-1:0][AW-1:0]  mask,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);

    logic [NCS-1:0] match;

    for (genvar g = 0; g < NCS; g++) begin : g_win
        assign match[g] = en[g] && ((addr & mask[g]) == (base[g] & mask[g]));
    end

    // Lowest index has priority: scan downward so the last write wins.
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = NCS - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/access_lane_calc.sv
module access_lane_calc
    import csbus_pkg::*;
(
    input  logic [1:0] beat_lo,
    input  tsize_e     size,
    input  pwidth_e    pw,
    input  logic       first,
    input  logic       burst,
    input  logic       wr,
    input  logic       rd_strobe,
    output logic [2:0] n,
    output logic [1:0] off,
    output tsize_e     tsiz,
    output logic [BUS_BYTES-1:0] be_n
);

    always_comb begin
        n    = access_bytes(size, pw);
        off  = beat_lo & port_mask(pw);
        tsiz = (first || burst) ? size : code_of(n);
        be_n = '1;
        for (int k = 0; k < BUS_BYTES; k++) begin
            if ((3'(k) >= {1'b0, off}) && (3'(k) < ({1'b0, off} + n)) && (wr || rd_strobe))
                be_n[BUS_BYTES-1-k] = 1'b0;
        end
    end

endmodule

// File: rtl/xfer_data_path.sv
module xfer_data_path
    import csbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [XFER_W-1:0] wdata,
    input  tsize_e            size,
    input  logic              step,
    input  logic [2:0]        n,
    input  logic [1:0]        off,
    input  logic [31:0]       din,
    output logic [31:0]       wword,
    output logic [XFER_W-1:0] rdata
);

    logic [XFER_W-1:0] wsh;
    logic [7:0]        lsh;
    logic [31:0]       aligned;
    logic [31:0]       grab;

    // Left-align the write bytes so the next byte to send is always on top.
    assign lsh     = 8'(XFER_W) - {size_bytes(size), 3'b000};
    assign wword   = wsh[XFER_W-1 -: 32] >> {off, 3'b000};
    assign aligned = din << {off, 3'b000};
    assign grab    = aligned >> (6'd32 - {n, 3'b000});

    always_ff @(posedge clk) begin
        if (rst) begin
            wsh   <= '0;
            rdata <= '0;
        end else if (load) begin
            wsh   <= wdata << lsh;
            rdata <= '0;
        end else if (step) begin
            wsh   <= wsh << {n, 3'b000};
            rdata <= (rdata << {n, 3'b000}) | {{(XFER_W-32){1'b0}}, grab};
        end
    end

endmodule

// File: rtl/cs_bus_seq.sv
module cs_bus_seq
    import csbus_pkg::*;
#(
    parameter int NCS    = 4,
    parameter int AW     = 32,
    parameter int WAIT_W = 4,
    localparam int IDX_W = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [AW-1:0]             req_addr,
    input  logic [1:0]                req_size,
    input  logic                      req_write,
    input  logic                      req_burst,
    input  logic [XFER_W-1:0]         req_wdata,
    output logic                      busy,
    output logic                      done,
    output logic                      done_err,
    output logic [XFER_W-1:0]         done_rdata,
    input  logic [NCS-1:0]            cfg_en,
    input  logic [NCS-1:0][AW-1:0]    cfg_base,
    input  logic [NCS-1:0][AW-1:0]    cfg_mask,
    input  logic [NCS-1:0][1:0]       cfg_pw,
    input  logic [NCS-1:0]            cfg_rd_strobe,
    input  logic [NCS-1:0]            cfg_auto_ack,
    input  logic [NCS-1:0][WAIT_W-1:0] cfg_waits,
    output logic [AW-1:0]             bus_addr,
    output logic                      bus_ale_n,
    output logic [NCS-1:0]            bus_cs_n,
    output logic                      bus_oe_n,
    output logic [BUS_BYTES-1:0]      bus_be_n,
    output logic [1:0]                bus_tsiz,
    output logic [31:0]               bus_dout,
    output logic                      bus_dout_en,
    input  logic [31:0]               bus_din,
    input  logic                      bus_ta_n
);

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_ADDR, ST_DATA, ST_GAP
    } state_e;

    state_e            st;
    req_ctx_t          ctx;
    win_attr_t         attr;
    logic [WAIT_W-1:0] waits;
    logic [WAIT_W-1:0] wcnt;
    logic [IDX_W-1:0]  win_idx;
    logic [AW-1:0]     beat_addr;
    logic [4:0]        beats_left;
    logic              first;

    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [2:0]        lc_n;
    logic [1:0]        lc_off;
    tsize_e            lc_tsiz;
    logic [BUS_BYTES-1:0] lc_be_n;
    logic [31:0]       wword;
    logic              accept;
    logic              beat_end;
    logic              do_launch;

    cs_window_match #(.NCS(NCS), .AW(AW)) u_match (
        .addr (req_addr),
        .en   (cfg_en),
        .base (cfg_base),
        .mask (cfg_mask),
        .hit  (hit),
        .idx  (hit_idx)
    );

    access_lane_calc u_lane (
        .beat_lo   (beat_addr[1:0]),
        .size      (ctx.size),
        .pw        (attr.pw),
        .first     (first),
        .burst     (ctx.burst),
        .wr        (ctx.wr),
        .rd_strobe (attr.rd_strobe),
        .n         (lc_n),
        .off       (lc_off),
        .tsiz      (lc_tsiz),
        .be_n      (lc_be_n)
    );

    assign accept    = (st == ST_IDLE) && req_valid && hit;
    assign beat_end  = (st == ST_DATA) && (attr.auto_ack ? (wcnt == waits) : !bus_ta_n);
    assign do_launch = (st == ST_SETUP) || ((st == ST_GAP) && (beats_left != '0));
    assign busy      = (st != ST_IDLE);

    xfer_data_path u_data (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .wdata (req_wdata),
        .size  (tsize_e'(req_size)),
        .step  (beat_end),
        .n     (lc_n),
        .off   (lc_off),
        .din   (bus_din),
        .wword (wword),
        .rdata (done_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            ctx         <= '0;
            attr        <= '0;
            waits       <= '0;
            wcnt        <= '0;
            win_idx     <= '0;
            beat_addr   <= '0;
            beats_left  <= '0;
            first       <= 1'b0;
            done        <= 1'b0;
            done_err    <= 1'b0;
            bus_addr    <= '0;
            bus_ale_n   <= 1'b1;
            bus_cs_n    <= '1;
            bus_oe_n    <= 1'b1;
            bus_be_n    <= '1;
            bus_tsiz    <= '0;
            bus_dout    <= '0;
            bus_dout_en <= 1'b0;
        end else begin
            done <= 1'b0;
            if (do_launch) begin
                bus_ale_n   <= 1'b0;
                bus_cs_n    <= ~(NCS'(1) << win_idx);
                bus_oe_n    <= ctx.wr;
                bus_be_n    <= lc_be_n;
                bus_tsiz    <= lc_tsiz;
                bus_addr    <= beat_addr;
                bus_dout    <= wword;
                bus_dout_en <= ctx.wr;
                st          <= ST_ADDR;
            end else begin
                case (st)
                    ST_IDLE: begin
                        if (req_valid) begin
                            if (hit) begin
                                ctx.size       <= tsize_e'(req_size);
                                ctx.wr         <= req_write;
                                ctx.burst      <= req_burst;
                                attr.pw        <= pwidth_e'(cfg_pw[hit_idx]);
                                attr.rd_strobe <= cfg_rd_strobe[hit_idx];
                                attr.auto_ack  <= cfg_auto_ack[hit_idx];
                                waits          <= cfg_waits[hit_idx];
                                win_idx        <= hit_idx;
                                beat_addr      <= req_addr;
                                beats_left     <= beat_count(tsize_e'(req_size),
                                                             pwidth_e'(cfg_pw[hit_idx]));
                                first          <= 1'b1;
                                done_err       <= 1'b0;
                                st             <= ST_SETUP;
                            end else begin
                                done     <= 1'b1;
                                done_err <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR: begin
                        bus_ale_n <= 1'b1;
                        wcnt      <= '0;
                        st        <= ST_DATA;
                    end
                    ST_DATA: begin
                        if (beat_end) begin
                            bus_cs_n   <= '1;
                            bus_oe_n   <= 1'b1;
                            bus_be_n   <= '1;
                            beat_addr  <= beat_addr + AW'(lc_n);
                            beats_left <= beats_left - 5'd1;
                            first      <= 1'b0;
                            st         <= ST_GAP;
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                    ST_GAP: begin
                        bus_dout_en <= 1'b0;
                        done        <= 1'b1;
                        st          <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    a_r13_ale_single: assert property (@(posedge clk) disable iff (rst)
        !bus_ale_n |=> bus_ale_n);

    a_r1_cs_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));

    a_r8_oe_read_only: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_n |-> (!ctx.wr && !(&bus_cs_n)));

    a_r11_data_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GAP && ctx.wr) |-> (bus_dout_en && $stable(bus_dout)));

    a_r2_err_quiet: assert property (@(posedge clk) disable iff (rst)
        (done && done_err) |-> (&bus_cs_n && bus_ale_n && bus_oe_n && &bus_be_n));

    a_r5_burst_code: assert property (@(posedge clk) disable iff (rst)
        (!bus_ale_n && ctx.burst) |-> (bus_tsiz == ctx.size));

    a_r9_wait_bound: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA && attr.auto_ack) |-> (wcnt <= waits));

endmodule

// File: tb/cs_bus_seq_tb.sv
`timescale 1ns/1ps
module cs_bus_seq_tb_top;
    import csbus_pkg::*;

    localparam int NCS = 4;
    localparam int AW  = 32;
    localparam int WW  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic                   req_valid = 1'b0;
    logic [AW-1:0]          req_addr  = '0;
    logic [1:0]             req_size  = '0;
    logic                   req_write = 1'b0;
    logic                   req_burst = 1'b0;
    logic [127:0]           req_wdata = '0;
    logic                   busy, done, done_err;
    logic [127:0]           done_rdata;
    logic [NCS-1:0]         cfg_en = '0;
    logic [NCS-1:0][AW-1:0] cfg_base = '0;
    logic [NCS-1:0][AW-1:0] cfg_mask = '0;
    logic [NCS-1:0][1:0]    cfg_pw = '0;
    logic [NCS-1:0]         cfg_rd_strobe = '0;
    logic [NCS-1:0]         cfg_auto_ack = '0;
    logic [NCS-1:0][WW-1:0] cfg_waits = '0;
    logic [AW-1:0]          bus_addr;
    logic                   bus_ale_n, bus_oe_n, bus_dout_en;
    logic [NCS-1:0]         bus_cs_n;
    logic [3:0]             bus_be_n;
    logic [1:0]             bus_tsiz;
    logic [31:0]            bus_dout;
    logic [31:0]            bus_din;
    logic                   bus_ta_n = 1'b1;

    cs_bus_seq #(.NCS(NCS), .AW(AW), .WAIT_W(WW)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_burst(req_burst), .req_wdata(req_wdata),
        .busy(busy), .done(done), .done_err(done_err), .done_rdata(done_rdata),
        .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_pw(cfg_pw),
        .cfg_rd_strobe(cfg_rd_strobe), .cfg_auto_ack(cfg_auto_ack), .cfg_waits(cfg_waits),
        .bus_addr(bus_addr), .bus_ale_n(bus_ale_n), .bus_cs_n(bus_cs_n),
        .bus_oe_n(bus_oe_n), .bus_be_n(bus_be_n), .bus_tsiz(bus_tsiz),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
        .bus_ta_n(bus_ta_n)
    );

    int checks = 0;
    int fails  = 0;

    // Expectations for the transaction in flight.
    logic [31:0] cur_addr = '0;
    int  cur_S = 1, cur_P = 4, cur_cs = 0, cur_wait = 0, cur_K = 2;
    bit  cur_wr = 0, cur_burst = 0, cur_rds = 0, cur_auto = 1, active = 0;
    int  mon_beat = 0, csl = 0;
    bit  prev_low = 0;
    logic [7:0]  wmem [16];
    logic [31:0] beat_dout = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(logic [31:0] a);
        return a[7:0] ^ 8'h5C ^ {a[9:8], 6'b0};
    endfunction

    function automatic logic [1:0] code_for(int b);
        case (b)
            1:       return 2'b01;
            2:       return 2'b10;
            16:      return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    // Memory model: a port of P bytes sits on lanes 0..P-1, lane 0 = [31:24].
    always_comb begin
        bus_din = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < cur_P)
                bus_din[31-8*k -: 8] = mem_byte((bus_addr & ~(32'(cur_P) - 32'd1)) + 32'(k));
            else
                bus_din[31-8*k -: 8] = 8'hEE;
        end
    end

    // Bus monitor and acknowledge driver, sampling away from the active edge.
    always @(negedge clk) begin
        bit cs_low;
        int n, off;
        logic [31:0] ea;
        logic [3:0]  eb;
        if (!rst) begin
            cs_low = (bus_cs_n != '1);
            if (!bus_ale_n) begin
                if (!active) begin
                    chk(1'b0, "R2", "address strobe with no transaction", 128'(bus_ale_n), 128'd1);
                end else begin
                    n   = (cur_S < cur_P) ? cur_S : cur_P;
                    ea  = cur_addr + 32'(mon_beat * n);
                    off = int'(ea % 32'(cur_P));
                    eb  = 4'hF;
                    for (int k = 0; k < 4; k++)
                        if (k >= off && k < off + n && (cur_wr || cur_rds)) eb[3-k] = 1'b0;
                    chk(mon_beat < cur_S / n, "R3", "extra access", 128'(mon_beat), 128'(cur_S / n));
                    chk(bus_addr == ea, "R3", "access address", 128'(bus_addr), 128'(ea));
                    if (cur_burst)
                        chk(bus_tsiz == code_for(cur_S), "R5", "burst size code",
                            128'(bus_tsiz), 128'(code_for(cur_S)));
                    else
                        chk(bus_tsiz == code_for(mon_beat == 0 ? cur_S : n), "R4", "size code",
                            128'(bus_tsiz), 128'(code_for(mon_beat == 0 ? cur_S : n)));
                    if (cur_wr || cur_rds)
                        chk(bus_be_n == eb, "R6", "byte strobes", 128'(bus_be_n), 128'(eb));
                    else
                        chk(bus_be_n == eb, "R7", "read strobes off", 128'(bus_be_n), 128'(eb));
                    chk(bus_oe_n == cur_wr, "R8", "output enable", 128'(bus_oe_n), 128'(cur_wr));
                    chk(bus_cs_n == ~(4'(1) << cur_cs), "R1", "chip select",
                        128'(bus_cs_n), 128'(~(4'(1) << cur_cs)));
                    if (cur_wr)
                        for (int k = off; k < off + n; k++)
                            wmem[int'(ea - cur_addr) + k - off] = bus_dout[31-8*k -: 8];
                    beat_dout = bus_dout;
                    mon_beat++;
                end
                csl = 0;
            end
            if (cs_low) csl++;
            if (prev_low && !cs_low && active) begin
                if (cur_auto)
                    chk(csl == cur_wait + 2, "R9", "auto-ack access length", 128'(csl), 128'(cur_wait + 2));
                else
                    chk(csl == cur_K, "R10", "external-ack access length", 128'(csl), 128'(cur_K));
                if (cur_wr)
                    chk(bus_dout_en && bus_dout == beat_dout, "R11", "data held after select",
                        {bus_dout_en, bus_dout}, {1'b1, beat_dout});
            end
            prev_low = cs_low;
            bus_ta_n <= cur_auto ? 1'b0 : !(cs_low && csl == cur_K);
        end
    end

    task automatic run_xfer(input int c, input logic [31:0] a, input int S,
                            input bit wr, input bit burst, input logic [127:0] wd);
        int n, t;
        logic [127:0] exp;
        cur_addr = a; cur_S = S; cur_cs = c; cur_wr = wr; cur_burst = burst;
        cur_P    = (cfg_pw[c] == 2'b00) ? 1 : (cfg_pw[c] == 2'b01) ? 2 : 4;
        cur_rds  = cfg_rd_strobe[c];
        cur_auto = cfg_auto_ack[c];
        cur_wait = int'(cfg_waits[c]);
        mon_beat = 0;
        for (int i = 0; i < 16; i++) wmem[i] = 8'h00;
        n = (S < cur_P) ? S : cur_P;
        @(negedge clk);
        active    = 1;
        req_addr  = a;
        req_size  = code_for(S);
        req_write = wr;
        req_burst = burst;
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(done && !done_err, "R1", "matched request completes", {done, done_err}, 2'b10);
        chk(mon_beat == S / n, "R3", "access count", 128'(mon_beat), 128'(S / n));
        chk(!bus_dout_en, "R11", "data released at done", 128'(bus_dout_en), 128'd0);
        if (wr) begin
            for (int i = 0; i < S; i++)
                chk(wmem[i] == wd[(S-1-i)*8 +: 8], "R6", "written byte",
                    128'(wmem[i]), 128'(wd[(S-1-i)*8 +: 8]));
        end else begin
            exp = '0;
            for (int i = 0; i < S; i++) exp = (exp << 8) | 128'(mem_byte(a + 32'(i)));
            chk(done_rdata == exp, "R12", "assembled read data", done_rdata, exp);
        end
        active = 0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int sizes [4] = '{1, 2, 4, 16};
        int S, offs, t;
        logic [127:0] wd;
        for (int c = 0; c < 4; c++) begin
            cfg_en[c]   = 1'b1;
            cfg_mask[c] = 32'hF000_0000;
            cfg_base[c] = (c == 3) ? 32'h3000_0000 : 32'(c + 1) << 28;
            cfg_pw[c]   = (c == 3) ? 2'b11 : 2'(c);
            cfg_auto_ack[c] = 1'b1;
            cfg_rd_strobe[c] = 1'b1;
            cfg_waits[c] = 4'd1;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_ale_n && &bus_cs_n && bus_oe_n && &bus_be_n, "R13", "strobes idle after reset",
            {bus_ale_n, bus_cs_n, bus_oe_n, bus_be_n}, 10'h3FF);
        chk(!busy && !done && !bus_dout_en, "R13", "idle after reset",
            {busy, done, bus_dout_en}, 3'b000);

        // Sweep: window 0/1/2 are 8/16/32-bit ports; window 3 overlaps window 2.
        for (int c = 0; c < 3; c++)
            for (int sz = 0; sz < 4; sz++)
                for (int w = 0; w < 2; w++)
                    for (int b = 0; b < 2; b++)
                        for (int k = 0; k < 2; k++) begin
                            S = sizes[sz];
                            offs = (k == 0) ? 0 : (S == 1) ? 3 : (S == 2) ? 2 : S;
                            cfg_rd_strobe[c] = 1'(k ^ b);
                            cfg_auto_ack[c]  = ((sz + k + w) % 2) == 0;
                            cfg_waits[c]     = 4'((c + sz + w) % 4);
                            cur_K            = 2 + (c + b + sz) % 3;
                            for (int i = 0; i < 16; i++)
                                wd[i*8 +: 8] = 8'(i * 29 + c * 7 + sz * 3 + w + 17);
                            run_xfer(c, cfg_base[c] + 32'h40 + 32'(offs), S, 1'(w), 1'(b), wd);
                        end

        // R1: a disabled window gives way to the next matching one.
        cfg_en[2] = 1'b0;
        cfg_waits[3] = 4'd2;
        run_xfer(3, 32'h3000_0088, 4, 1'b0, 1'b0, '0);
        cfg_en[2] = 1'b1;

        // R2: unmatched address finishes at once without bus activity.
        @(negedge clk);
        active    = 0;
        req_addr  = 32'h5000_0010;
        req_size  = 2'b00;
        req_write = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done && done_err, "R2", "error completion next cycle", {done, done_err}, 2'b11);
        t = 0;
        repeat (4) begin
            @(negedge clk);
            if (!bus_ale_n || bus_cs_n != '1 || !bus_oe_n || bus_be_n != '1) t++;
        end
        chk(t == 0 && !busy, "R2", "no strobes for unmatched address", 128'(t), 128'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule